// File: doc/BRIEF.md
# Power-Management Register Bank with Interrupt Logic

This block is the register bank that sits behind the serial bus slave of a power-management companion device. The slave decodes each bus frame into a device address, a read/write flag, a 5-bit register index and a 16-bit data word. It then presents this to the bank as a single-cycle access strobe. The bank answers only to its own device address. Reads return their data one cycle later, flagged by a valid strobe.

The bank holds the following state:
- an identification word, with a variant bit driven from a strap pin;
- interrupt status and mask registers; status bits are acknowledged by writing them back, which toggles them;
- an ADC channel selector whose readback packs the channel number above that channel's result;
- a set-once sample-control word whose bits are cleared by writing ones;
- a calibration register and two common control registers;
- a status word whose bit 5 tracks the power button;
- a watchdog index. Writing zero to it while an arm bit is set emits a one-cycle shutdown request.

Two hardware events feed the interrupt status: a power-button event and an ADC sample-done event. A per-channel table of ADC results is loaded from a side port. This stands in for a real converter. Unimplemented indices read as zero and ignore writes.

Top module: `pmic_regbank`

## Requirements
- R1: After reset the interrupt mask (index 0x02) reads 0xFFFF, the interrupt status (index 0x01) reads 0x0000, the status word (index 0x16) reads 0x0020 and the calibration register (index 0x06) reads 0x0001. After reset, irqOut and shutdownReq are low.
- R2: irqOut is high exactly when some bit is set in the interrupt status and clear in the mask. The mask at index 0x02 is read/write.
- R3: A write to index 0x01 XORs the written word into the interrupt status. A read of index 0x01 returns the raw status.
- R4: Index 0x00 is read-only and returns 0x0215, with bit 7 also set while variantStrap is high.
- R5: A write to index 0x08 selects the channel from data bits 13:10 and sets interrupt status bit 8. A read of index 0x08 returns the channel in bits 13:10 and that channel's 10-bit result from the loaded table in bits 9:0. A pulse on adcDone also sets status bit 8.
- R6: The sample-control word (index 0x09) resets to 0x00F0. A write clears each bit written as 1 and leaves the other bits unchanged.
- R7: Writing 0x0000 to index 0x17 while bit 1 of common control 1 (index 0x0D) is set raises shutdownReq for exactly the cycle after the write. A nonzero value, or the arm bit clear, raises nothing. Index 0x17 reads as 0.
- R8: A keyEvent pulse sets interrupt status bit 0. It also sets status-word bit 5 to the inverse of keyDown: 0 while the button is pressed, 1 when it is released.
- R9: Calibration (0x06), common control 1 (0x0D) and common control 2 (0x0E) are read/write.
- R10: Only accesses with devAddr equal to 1 have any effect. Other addresses change no state and produce no rdValid.
- R11: Unimplemented indices (for example 0x03 and 0x1A) read as 0, and writes to them change no state.
- R12: When an event sets an interrupt status bit in the same cycle that a write to 0x01 would toggle it off, the bit ends set.
- R13: The read data appears on rdData, with rdValid high, in the cycle after the read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devAddr | input | 3 | Device address of the current access |
| accValid | input | 1 | Access strobe, one cycle per register access |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accIndex | input | 5 | Register index |
| accWdata | input | 16 | Write data |
| rdData | output | 16 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after a read access |
| variantStrap | input | 1 | Variant strap, reflected in identification bit 7 |
| keyEvent | input | 1 | Power-button event pulse |
| keyDown | input | 1 | Button level sampled with keyEvent, 1 for pressed |
| adcDone | input | 1 | ADC sample-done event pulse |
| resLoad | input | 1 | Load strobe for the result table |
| resChan | input | 4 | Channel written by resLoad |
| resData | input | 10 | Result written by resLoad |
| irqOut | output | 1 | Level interrupt output |
| shutdownReq | output | 1 | One-cycle shutdown request |

## Verification
The hardest case to reach from the ports is a status bit that is acknowledged by a bus write in the same cycle that a new event sets it. The bit must already be set, and the bus access and the event must land on the same edge. To get there, the stimulus first raises the bit with a button release. It then drives the write strobe and keyEvent together on one negedge and reads the status back. The watchdog path is also exercised in full: the bench covers the arm bit clear, a nonzero value, a wrong device address, and the single armed case. It checks that the pulse lasts one cycle.

// File: rtl/pmic_regbank_pkg.sv
package pmic_regbank_pkg;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 5;

  localparam logic [IDX_W-1:0] IDX_ID   = 5'h00;
  localparam logic [IDX_W-1:0] IDX_IRQ  = 5'h01;
  localparam logic [IDX_W-1:0] IDX_MASK = 5'h02;
  localparam logic [IDX_W-1:0] IDX_CAL  = 5'h06;
  localparam logic [IDX_W-1:0] IDX_ADC  = 5'h08;
  localparam logic [IDX_W-1:0] IDX_SAMP = 5'h09;
  localparam logic [IDX_W-1:0] IDX_CCR1 = 5'h0D;
  localparam logic [IDX_W-1:0] IDX_CCR2 = 5'h0E;
  localparam logic [IDX_W-1:0] IDX_STAT = 5'h16;
  localparam logic [IDX_W-1:0] IDX_WDOG = 5'h17;

  localparam logic [DATA_W-1:0] ID_VALUE   = 16'h0215;
  localparam logic [DATA_W-1:0] MASK_RST   = 16'hFFFF;
  localparam logic [DATA_W-1:0] STAT_RST   = 16'h0020;
  localparam logic [DATA_W-1:0] CAL_RST    = 16'h0001;
  localparam int                VAR_BIT    = 7;
  localparam int                IRQ_KEY    = 0;
  localparam int                IRQ_ADC    = 8;
  localparam int                KEY_BIT    = 5;
  localparam int                ARM_BIT    = 1;

  typedef struct packed {
    logic wrIrq;
    logic wrMask;
    logic wrCal;
    logic wrAdc;
    logic wrSamp;
    logic wrCcr1;
    logic wrCcr2;
    logic wrWdog;
    logic rdEn;
  } bankStrobes_t;
endpackage

// File: rtl/pmic_regbank_ctrl.sv
module pmic_regbank_ctrl
  import pmic_regbank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DEV_ADDR = 1
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [IDX_W-1:0]  accIndex,
  output bankStrobes_t      strb
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ADDR);

  logic hit;
  logic wrHit;

  assign hit   = accValid && (devAddr == MY_ADDR);
  assign wrHit = hit && accWrite;

  always_comb begin
    strb        = '0;
    strb.rdEn   = hit && !accWrite;
    strb.wrIrq  = wrHit && (accIndex == IDX_IRQ);
    strb.wrMask = wrHit && (accIndex == IDX_MASK);
    strb.wrCal  = wrHit && (accIndex == IDX_CAL);
    strb.wrAdc  = wrHit && (accIndex == IDX_ADC);
    strb.wrSamp = wrHit && (accIndex == IDX_SAMP);
    strb.wrCcr1 = wrHit && (accIndex == IDX_CCR1);
    strb.wrCcr2 = wrHit && (accIndex == IDX_CCR2);
    strb.wrWdog = wrHit && (accIndex == IDX_WDOG);
  end
endmodule

// File: rtl/pmic_regbank_dp.sv
module pmic_regbank_dp
  import pmic_regbank_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int RES_W = 10,
  parameter logic [DATA_W-1:0] SAMPLE_RST = 16'h00F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strb,
  input  logic [IDX_W-1:0]  accIndex,
  input  logic [DATA_W-1:0] accWdata,
  input  logic              variantStrap,
  input  logic              keyEvent,
  input  logic              keyDown,
  input  logic              adcDone,
  input  logic              resLoad,
  input  logic [CHAN_W-1:0] resChan,
  input  logic [RES_W-1:0]  resData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              irqOut,
  output logic              shutdownReq,
  output logic [DATA_W-1:0] irqSt,
  output logic [DATA_W-1:0] irqMask
);
  localparam int NCH = 1 << CHAN_W;

  logic [NCH-1:0][RES_W-1:0] resTab;
  logic [CHAN_W-1:0]         adcChan;
  logic [DATA_W-1:0]         calReg, ccr1Reg, ccr2Reg, sampReg, statReg;
  logic [DATA_W-1:0]         evtSet, toggle, rdNext, idVal, adcVal;

  always_ff @(posedge clk) begin
    if (!rstN) resTab <= '0;
    else if (resLoad) resTab[resChan] <= resData;
  end

  always_comb begin
    evtSet = '0;
    if (keyEvent) evtSet[IRQ_KEY] = 1'b1;
    if (adcDone || strb.wrAdc) evtSet[IRQ_ADC] = 1'b1;
    toggle = strb.wrIrq ? accWdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqSt       <= '0;
      irqMask     <= MASK_RST;
      calReg      <= CAL_RST;
      ccr1Reg     <= '0;
      ccr2Reg     <= '0;
      sampReg     <= SAMPLE_RST;
      statReg     <= STAT_RST;
      adcChan     <= '0;
      shutdownReq <= 1'b0;
    end else begin
      irqSt <= (irqSt ^ toggle) | evtSet;
      if (strb.wrMask) irqMask <= accWdata;
      if (strb.wrCal)  calReg  <= accWdata;
      if (strb.wrCcr1) ccr1Reg <= accWdata;
      if (strb.wrCcr2) ccr2Reg <= accWdata;
      if (strb.wrSamp) sampReg <= sampReg & ~accWdata;
      if (strb.wrAdc)  adcChan <= accWdata[RES_W +: CHAN_W];
      if (keyEvent)    statReg[KEY_BIT] <= !keyDown;
      shutdownReq <= strb.wrWdog && (accWdata == '0) && ccr1Reg[ARM_BIT];
    end
  end

  assign irqOut = |(irqSt & ~irqMask);

  always_comb begin
    idVal = ID_VALUE;
    idVal[VAR_BIT] = idVal[VAR_BIT] | variantStrap;
    adcVal = '0;
    adcVal[RES_W +: CHAN_W] = adcChan;
    adcVal[RES_W-1:0] = resTab[adcChan];
    case (accIndex)
      IDX_ID:   rdNext = idVal;
      IDX_IRQ:  rdNext = irqSt;
      IDX_MASK: rdNext = irqMask;
      IDX_CAL:  rdNext = calReg;
      IDX_ADC:  rdNext = adcVal;
      IDX_SAMP: rdNext = sampReg;
      IDX_CCR1: rdNext = ccr1Reg;
      IDX_CCR2: rdNext = ccr2Reg;
      IDX_STAT: rdNext = statReg;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
  import pmic_regbank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DEV_ADDR = 1,
  parameter int CHAN_W = 4,
  parameter int RES_W = 10,
  parameter logic [15:0] SAMPLE_RST = 16'h00F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [4:0]        accIndex,
  input  logic [15:0]       accWdata,
  output logic [15:0]       rdData,
  output logic              rdValid,
  input  logic              variantStrap,
  input  logic              keyEvent,
  input  logic              keyDown,
  input  logic              adcDone,
  input  logic              resLoad,
  input  logic [CHAN_W-1:0] resChan,
  input  logic [RES_W-1:0]  resData,
  output logic              irqOut,
  output logic              shutdownReq
);
  bankStrobes_t      strb;
  logic [DATA_W-1:0] irqSt;
  logic [DATA_W-1:0] irqMask;

  pmic_regbank_ctrl #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) ctrl_i (
    .accValid(accValid), .accWrite(accWrite), .devAddr(devAddr),
    .accIndex(accIndex), .strb(strb)
  );

  pmic_regbank_dp #(.CHAN_W(CHAN_W), .RES_W(RES_W), .SAMPLE_RST(SAMPLE_RST)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .accIndex(accIndex),
    .accWdata(accWdata), .variantStrap(variantStrap), .keyEvent(keyEvent),
    .keyDown(keyDown), .adcDone(adcDone), .resLoad(resLoad),
    .resChan(resChan), .resData(resData), .rdData(rdData),
    .rdValid(rdValid), .irqOut(irqOut), .shutdownReq(shutdownReq),
    .irqSt(irqSt), .irqMask(irqMask)
  );
endmodule

// File: rtl/pmic_regbank_chk.sv
module pmic_regbank_chk #(
  parameter int ADDR_W = 3,
  parameter int DEV_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] devAddr,
  input logic              accValid,
  input logic              accWrite,
  input logic [4:0]        accIndex,
  input logic [15:0]       accWdata,
  input logic              keyEvent,
  input logic              adcDone,
  input logic              irqOut,
  input logic              shutdownReq,
  input logic              rdValid,
  input logic [15:0]       irqSt,
  input logic [15:0]       irqMask
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ADDR);

  // R7
  shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(accValid && accWrite && devAddr == MY_ADDR &&
                          accIndex == 5'h17 && accWdata == 16'h0000));

  // R8
  key_sets_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyEvent |=> irqSt[0]);

  // R5
  adc_sets_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcDone |=> irqSt[8]);

  // R13
  rd_valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(accValid && !accWrite && devAddr == MY_ADDR));

  // R10
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && devAddr != MY_ADDR && !keyEvent && !adcDone) |=>
      ($stable(irqMask) && $stable(irqSt)));

  // R2
  irq_fall_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(accValid && accWrite));
endmodule

bind pmic_regbank pmic_regbank_chk #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) chk_i (
  .clk(clk), .rstN(rstN), .devAddr(devAddr), .accValid(accValid),
  .accWrite(accWrite), .accIndex(accIndex), .accWdata(accWdata),
  .keyEvent(keyEvent), .adcDone(adcDone), .irqOut(irqOut),
  .shutdownReq(shutdownReq), .rdValid(rdValid), .irqSt(irqSt),
  .irqMask(irqMask)
);

// File: tb/pmic_regbank_tb_top.sv
`timescale 1ns/1ps
module pmic_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  devAddr = 3'd1;
  logic        accValid = 0, accWrite = 0;
  logic [4:0]  accIndex = '0;
  logic [15:0] accWdata = '0;
  logic [15:0] rdData;
  logic        rdValid;
  logic        variantStrap = 0, keyEvent = 0, keyDown = 0, adcDone = 0;
  logic        resLoad = 0;
  logic [3:0]  resChan = '0;
  logic [9:0]  resData = '0;
  logic        irqOut, shutdownReq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string tag; } rdItem_t;
  rdItem_t sbQ[$];

  always #2.5 clk = ~clk;

  pmic_regbank dut_i (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .accValid(accValid),
    .accWrite(accWrite), .accIndex(accIndex), .accWdata(accWdata),
    .rdData(rdData), .rdValid(rdValid), .variantStrap(variantStrap),
    .keyEvent(keyEvent), .keyDown(keyDown), .adcDone(adcDone),
    .resLoad(resLoad), .resChan(resChan), .resData(resData),
    .irqOut(irqOut), .shutdownReq(shutdownReq)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] idx, input logic [15:0] data,
                       input logic [2:0] addr = 3'd1);
    @(negedge clk);
    accValid = 1; accWrite = 1; accIndex = idx; accWdata = data; devAddr = addr;
    @(negedge clk);
    accValid = 0; accWrite = 0; devAddr = 3'd1;
  endtask

  task automatic busRd(input logic [4:0] idx, input logic [15:0] exp,
                       input string tag, input logic [2:0] addr = 3'd1);
    rdItem_t it;
    @(negedge clk);
    accValid = 1; accWrite = 0; accIndex = idx; devAddr = addr;
    if (addr == 3'd1) begin
      it.exp = exp; it.tag = tag;
      sbQ.push_back(it);
    end
    @(negedge clk);
    accValid = 0; devAddr = 3'd1;
  endtask

  task automatic pulseKey(input logic down);
    @(negedge clk);
    keyEvent = 1; keyDown = down;
    @(negedge clk);
    keyEvent = 0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rdValid) begin
      if (sbQ.size() == 0) chk(1'b0, "R10 unexpected rdValid", rdData, 16'h0);
      else begin
        rdItem_t it;
        it = sbQ.pop_front();
        chk(rdData === it.exp, it.tag, rdData, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(irqOut === 1'b0, "R1 irqOut after reset", {15'b0, irqOut}, 16'h0);
    chk(shutdownReq === 1'b0, "R1 shutdownReq after reset", {15'b0, shutdownReq}, 16'h0);
    chk(rdValid === 1'b0, "R13 rdValid idle", {15'b0, rdValid}, 16'h0);
    busRd(5'h02, 16'hFFFF, "R1 mask reset");
    busRd(5'h01, 16'h0000, "R1 irq status reset");
    busRd(5'h16, 16'h0020, "R1 status word reset");
    busRd(5'h06, 16'h0001, "R1 calibration reset");
    // R4 identification
    busRd(5'h00, 16'h0215, "R4 id strap low");
    variantStrap = 1;
    busRd(5'h00, 16'h0295, "R4 id strap high");
    busWr(5'h00, 16'h0000);
    busRd(5'h00, 16'h0295, "R4 id read-only");
    // R8 press
    pulseKey(1'b1);
    busRd(5'h01, 16'h0001, "R8 key sets irq bit0");
    busRd(5'h16, 16'h0000, "R8 pressed clears bit5");
    chk(irqOut === 1'b0, "R2 masked irq", {15'b0, irqOut}, 16'h0);
    busWr(5'h02, 16'hFFFE);
    chk(irqOut === 1'b1, "R2 unmasked irq", {15'b0, irqOut}, 16'h1);
    busRd(5'h02, 16'hFFFE, "R2 mask readback");
    // R3 XOR acknowledge
    busWr(5'h01, 16'h0001);
    chk(irqOut === 1'b0, "R3 xor ack drops irq", {15'b0, irqOut}, 16'h0);
    busWr(5'h01, 16'h0006);
    busRd(5'h01, 16'h0006, "R3 xor sets bits");
    chk(irqOut === 1'b0, "R2 masked toggled bits", {15'b0, irqOut}, 16'h0);
    busWr(5'h01, 16'h0006);
    busRd(5'h01, 16'h0000, "R3 xor clears bits");
    // R8 release
    pulseKey(1'b0);
    busRd(5'h16, 16'h0020, "R8 released sets bit5");
    // R12 event beats same-cycle toggle
    @(negedge clk);
    accValid = 1; accWrite = 1; accIndex = 5'h01; accWdata = 16'h0001;
    keyEvent = 1; keyDown = 0;
    @(negedge clk);
    accValid = 0; accWrite = 0; keyEvent = 0;
    busRd(5'h01, 16'h0001, "R12 event wins over toggle");
    busWr(5'h01, 16'h0001);
    busRd(5'h01, 16'h0000, "R3 ack after merge");
    // R5 ADC
    @(negedge clk); resLoad = 1; resChan = 4'd5; resData = 10'h3FF;
    @(negedge clk); resChan = 4'd13; resData = 10'h330;
    @(negedge clk); resLoad = 0;
    busWr(5'h08, 16'h1400);
    busRd(5'h08, 16'h17FF, "R5 adc channel 5");
    busRd(5'h01, 16'h0100, "R5 adc write sets bit8");
    busWr(5'h08, 16'h3400);
    busRd(5'h08, 16'h3730, "R5 adc channel 13");
    busWr(5'h01, 16'h0100);
    @(negedge clk); adcDone = 1;
    @(negedge clk); adcDone = 0;
    busRd(5'h01, 16'h0100, "R5 adcDone sets bit8");
    busWr(5'h01, 16'h0100);
    // R6 sample control
    busRd(5'h09, 16'h00F0, "R6 sample reset");
    busWr(5'h09, 16'h0030);
    busRd(5'h09, 16'h00C0, "R6 clear written ones");
    busWr(5'h09, 16'hFF0F);
    busRd(5'h09, 16'h00C0, "R6 zeros leave bits");
    // R9 read/write registers
    busWr(5'h06, 16'h1234);
    busRd(5'h06, 16'h1234, "R9 calibration");
    busWr(5'h0E, 16'hBEEF);
    busRd(5'h0E, 16'hBEEF, "R9 control 2");
    // R7 watchdog
    busWr(5'h0D, 16'h0000);
    busWr(5'h17, 16'h0000);
    chk(shutdownReq === 1'b0, "R7 unarmed no shutdown", {15'b0, shutdownReq}, 16'h0);
    busWr(5'h0D, 16'h0002);
    busRd(5'h0D, 16'h0002, "R9 control 1");
    busWr(5'h17, 16'h0005);
    chk(shutdownReq === 1'b0, "R7 nonzero no shutdown", {15'b0, shutdownReq}, 16'h0);
    busWr(5'h17, 16'h0000, 3'd2);
    chk(shutdownReq === 1'b0, "R10 foreign watchdog write", {15'b0, shutdownReq}, 16'h0);
    busWr(5'h17, 16'h0000);
    chk(shutdownReq === 1'b1, "R7 armed shutdown pulse", {15'b0, shutdownReq}, 16'h1);
    @(negedge clk);
    chk(shutdownReq === 1'b0, "R7 pulse one cycle", {15'b0, shutdownReq}, 16'h0);
    busRd(5'h17, 16'h0000, "R7 watchdog reads zero");
    // R11 unimplemented
    busWr(5'h1A, 16'hFFFF);
    busWr(5'h03, 16'hFFFF);
    busRd(5'h1A, 16'h0000, "R11 index 0x1A reads zero");
    busRd(5'h03, 16'h0000, "R11 index 0x03 reads zero");
    busRd(5'h02, 16'hFFFE, "R11 mask untouched");
    // R10 foreign address
    busWr(5'h02, 16'h0000, 3'd2);
    busRd(5'h02, 16'hFFFE, "R10 foreign write ignored");
    busRd(5'h02, 16'h0000, "R10 foreign read silent", 3'd2);
    @(negedge clk);
    chk(sbQ.size() == 0, "R13 scoreboard drained", 16'(sbQ.size()), 16'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule